// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt and a critical interrupt. Every line can be set to edge or level detection, and can be routed to either output. Pending requests are latched in a status register and gated by an enable mask. Software reaches the block through a simple word-wide register port with nine registers at consecutive offsets.

For fast dispatch of critical requests, the block also keeps a vector register. Its value is a software-chosen base address plus a fixed 512-byte stride times the position of the winning pending critical request. The scan that picks the winner can run from either end of the status word. A parameter removes the vector logic. The status, masked-status and vector values are kept up to date as requests arrive. Both interrupt outputs and the vector are registered and follow the internal state one cycle later.

Top module: `vic_ctrl`

## Requirements
- R1: Offsets: 0 status (write 1 to clear), 1 status set, 2 enable, 3 critical select, 4 polarity, 5 trigger mode, 6 masked status, 7 vector, 8 vector config. Offsets 2, 3, 4 and 5 read back the last value written. Reading offset 1 returns the status. Polarity has no effect on detection.
- R2: Request input n drives status bit 31-n, so input 0 is the most significant status bit.
- R3: A trigger-mode bit of 0 selects level detection. That status bit follows its input every cycle, so writing a one to clear it at offset 0 has no lasting effect while the input stays high.
- R4: A trigger-mode bit of 1 selects edge detection. Only a 0-to-1 change on the input sets the status bit. The bit then stays set after the input falls, until a one is written to it at offset 0. An input held high does not set the bit again.
- R5: Writing offset 1 ORs the written word into status.
- R6: The normal output is high one cycle after (status & enable & ~critical) becomes nonzero, and low one cycle after it becomes zero.
- R7: The critical output behaves the same way for (status & enable & critical).
- R8: Reading offset 6 returns status AND enable.
- R9: A write to offset 8 stores the word with bit 1 forced to 0. The vector is the stored word with bits 1:0 cleared, plus 512 times k. With config bit 0 = 0, k is the lowest set bit index i of the pending critical set. With config bit 0 = 1, k is 31 minus the highest set bit index i.
- R10: The vector reads zero whenever no enabled critical request is pending.
- R11: With vector support turned off by parameter, offsets 7 and 8 always read zero.
- R12: Writes to offsets 6, 7 and above 8 change nothing. Reads of offsets above 8 return zero.
- R13: After reset every register reads zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | input | 32 | Request inputs, input n maps to status bit 31-n |
| irq_norm | output | 1 | Normal interrupt output, registered |
| irq_crit | output | 1 | Critical interrupt output, registered |

## Verification
The bench writes a one to clear a level request whose input is still high. A design that lets the clear win would drop the normal output for a cycle or longer. It holds an edge input high across a clear, to catch a detector that compares against the wrong sample and sets the bit again. It sets two critical bits at the far ends of the range and checks the vector in both scan directions. A reversed scan or a stride shifted by one bit gives a different address, and a config write that keeps bit 1 reads back one number off. It also writes the read-only and unused offsets, reads a second instance with vector support removed, and drives input 31 to check the bit reversal at its far end.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned OFS_W = 4;

  // Register word offsets; the order is fixed because software decodes it.
  localparam logic [OFS_W-1:0] OFS_STAT  = 4'd0;
  localparam logic [OFS_W-1:0] OFS_SSET  = 4'd1;
  localparam logic [OFS_W-1:0] OFS_EN    = 4'd2;
  localparam logic [OFS_W-1:0] OFS_CRIT  = 4'd3;
  localparam logic [OFS_W-1:0] OFS_POL   = 4'd4;
  localparam logic [OFS_W-1:0] OFS_TRIG  = 4'd5;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 4'd6;
  localparam logic [OFS_W-1:0] OFS_VEC   = 4'd7;
  localparam logic [OFS_W-1:0] OFS_VCFG  = 4'd8;
endpackage

// File: rtl/vic_detect.sv
module vic_detect #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_in,
  output logic [N_SRC-1:0] lvl_sb,
  output logic [N_SRC-1:0] rise_sb
);
  logic [N_SRC-1:0] req_prev_q;
  logic [N_SRC-1:0] rise_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev_q <= '0;
    else        req_prev_q <= req_in;
  end

  assign rise_in = req_in & ~req_prev_q;

  // Input n lands on status bit N_SRC-1-n.
  for (genvar g = 0; g < N_SRC; g++) begin : g_map
    assign lvl_sb[N_SRC-1-g]  = req_in[g];
    assign rise_sb[N_SRC-1-g] = rise_in[g];
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC   = 32,
  parameter bit          HAS_VEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] addr,
  input  logic [N_SRC-1:0] wdata,
  input  logic [N_SRC-1:0] lvl_sb,
  input  logic [N_SRC-1:0] rise_sb,
  output logic [N_SRC-1:0] status,
  output logic [N_SRC-1:0] en,
  output logic [N_SRC-1:0] crit,
  output logic [N_SRC-1:0] pol,
  output logic [N_SRC-1:0] trig,
  output logic [N_SRC-1:0] vcfg
);
  localparam logic [N_SRC-1:0] VCFG_MASK = ~(N_SRC'(2));

  logic [N_SRC-1:0] stat_q, stat_d;
  logic [N_SRC-1:0] en_q, crit_q, pol_q, trig_q, vcfg_q;
  logic             en_we, crit_we, pol_we, trig_we, vcfg_we;
  logic [N_SRC-1:0] held;

  assign held = lvl_sb & ~trig_q;

  always_comb begin
    en_we   = wr && (addr == OFS_EN);
    crit_we = wr && (addr == OFS_CRIT);
    pol_we  = wr && (addr == OFS_POL);
    trig_we = wr && (addr == OFS_TRIG);
    vcfg_we = wr && (addr == OFS_VCFG) && HAS_VEC;

    stat_d = stat_q;
    if (wr && (addr == OFS_STAT)) stat_d = (stat_d & ~wdata) | held;
    if (wr && (addr == OFS_SSET)) stat_d = stat_d | wdata;
    // Edge lines latch a rising input; level lines track the input.
    stat_d = stat_d | (rise_sb & trig_q);
    stat_d = (stat_d & trig_q) | held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      vcfg_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_we)   en_q   <= wdata;
      if (crit_we) crit_q <= wdata;
      if (pol_we)  pol_q  <= wdata;
      if (trig_we) trig_q <= wdata;
      if (vcfg_we) vcfg_q <= wdata & VCFG_MASK;
    end
  end

  assign status = stat_q;
  assign en     = en_q;
  assign crit   = crit_q;
  assign pol    = pol_q;
  assign trig   = trig_q;
  assign vcfg   = vcfg_q;
endmodule

// File: rtl/vic_scan.sv
module vic_scan #(
  parameter int unsigned N_SRC     = 32,
  parameter int unsigned STRIDE_SH = 9
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] vcfg,
  output logic [N_SRC-1:0] vec
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [IDX_W-1:0] idx_lo, idx_hi, step;

  always_comb begin
    idx_lo = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx_lo = IDX_W'(i);
    end
    idx_hi = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i]) idx_hi = IDX_W'(i);
    end
    step = vcfg[0] ? (IDX_W'(N_SRC - 1) - idx_hi) : idx_lo;
    if (pend == '0) vec = '0;
    else            vec = {vcfg[N_SRC-1:2], 2'b00} + (N_SRC'(step) << STRIDE_SH);
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC     = 32,
  parameter bit          HAS_VEC   = 1'b1,
  parameter int unsigned STRIDE_SH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [31:0]      irq_req,
  output logic             irq_norm,
  output logic             irq_crit
);
  logic [N_SRC-1:0] lvl_sb, rise_sb;
  logic [N_SRC-1:0] status_q, en_q, crit_q, pol_q, trig_q, vcfg_q;
  logic [N_SRC-1:0] norm_pend, crit_pend, vec_q;
  logic             norm_q, critout_q;

  vic_detect #(.N_SRC(N_SRC)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (irq_req),
    .lvl_sb  (lvl_sb),
    .rise_sb (rise_sb)
  );

  vic_regs #(.N_SRC(N_SRC), .HAS_VEC(HAS_VEC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .lvl_sb  (lvl_sb),
    .rise_sb (rise_sb),
    .status  (status_q),
    .en      (en_q),
    .crit    (crit_q),
    .pol     (pol_q),
    .trig    (trig_q),
    .vcfg    (vcfg_q)
  );

  assign norm_pend = status_q & en_q & ~crit_q;
  assign crit_pend = status_q & en_q & crit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q    <= 1'b0;
      critout_q <= 1'b0;
    end else begin
      norm_q    <= |norm_pend;
      critout_q <= |crit_pend;
    end
  end

  if (HAS_VEC) begin : g_vec
    logic [N_SRC-1:0] vec_d;
    vic_scan #(.N_SRC(N_SRC), .STRIDE_SH(STRIDE_SH)) u_scan (
      .pend (crit_pend),
      .vcfg (vcfg_q),
      .vec  (vec_d)
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= '0;
      else        vec_q <= vec_d;
    end
  end else begin : g_novec
    assign vec_q = '0;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_STAT, OFS_SSET: reg_rdata = status_q;
      OFS_EN:             reg_rdata = en_q;
      OFS_CRIT:           reg_rdata = crit_q;
      OFS_POL:            reg_rdata = pol_q;
      OFS_TRIG:           reg_rdata = trig_q;
      OFS_MSTAT:          reg_rdata = status_q & en_q;
      OFS_VEC:            reg_rdata = HAS_VEC ? vec_q : '0;
      OFS_VCFG:           reg_rdata = HAS_VEC ? vcfg_q : '0;
      default:            reg_rdata = '0;
    endcase
  end

  assign irq_norm = norm_q;
  assign irq_crit = critout_q;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int unsigned N_SRC   = 32,
  parameter bit          HAS_VEC = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [3:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      irq_req,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] en,
  input logic [N_SRC-1:0] crit,
  input logic [N_SRC-1:0] pol,
  input logic [N_SRC-1:0] trig,
  input logic [N_SRC-1:0] vcfg,
  input logic [N_SRC-1:0] vec,
  input logic             irq_norm,
  input logic             irq_crit
);
  logic [N_SRC-1:0] req_rev, lvl_hi, lvl_lo;
  logic             ro_wr;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) req_rev[N_SRC-1-i] = irq_req[i];
  end
  assign lvl_hi = req_rev & ~trig;
  assign lvl_lo = ~req_rev & ~trig;
  assign ro_wr  = reg_wr && ((reg_addr == 4'd6) || (reg_addr == 4'd7) || (reg_addr > 4'd8));

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status & $past(lvl_hi)) == $past(lvl_hi)) && ((status & $past(lvl_lo)) == '0)));

  // R6
  norm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_norm == $past(|(status & en & ~crit))));

  // R10
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_crit |-> (vec == '0));

  // R12
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr |=> ($stable(en) && $stable(crit) && $stable(pol) && $stable(trig) && $stable(vcfg)));

  if (HAS_VEC) begin : g_vcfg_chk
    // R9
    vcfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 4'd8) |=> (vcfg == ($past(reg_wdata) & ~32'h2)));
  end
endmodule

bind vic_ctrl vic_ctrl_chk #(.N_SRC(N_SRC), .HAS_VEC(HAS_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_req   (irq_req),
  .status    (status_q),
  .en        (en_q),
  .crit      (crit_q),
  .pol       (pol_q),
  .trig      (trig_q),
  .vcfg      (vcfg_q),
  .vec       (vec_q),
  .irq_norm  (irq_norm),
  .irq_crit  (irq_crit)
);

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] irq_req = '0;
  logic [31:0] rdata, rdata_nv;
  logic        irq_norm, irq_crit, irq_norm_nv, irq_crit_nv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vic_ctrl u_vic_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq_req(irq_req),
    .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  vic_ctrl #(.HAS_VEC(1'b0)) u_vic_ctrl_nv (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_nv), .irq_req(irq_req),
    .irq_norm(irq_norm_nv), .irq_crit(irq_crit_nv)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [31:0] irq;
    logic [3:0]  raddr;
    logic [31:0] exp;
    logic        n;
    logic        c;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd2, 32'hFFFFFFFF, 32'h0, 4'd2, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd1},  // R1 enable all
    '{1'b0, 4'd0, 32'h0, 32'h1, 4'd0, 32'h80000000, 1'b1, 1'b0, 8'd2},         // R2 input 0 -> bit 31
    '{1'b1, 4'd0, 32'h80000000, 32'h1, 4'd0, 32'h80000000, 1'b1, 1'b0, 8'd3},  // R3 clear while held
    '{1'b0, 4'd0, 32'h0, 32'h0, 4'd0, 32'h0, 1'b0, 1'b0, 8'd3},                // R3 level drops
    '{1'b1, 4'd5, 32'hFFFFFFFF, 32'h0, 4'd5, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd1},  // R1 all edge
    '{1'b0, 4'd0, 32'h0, 32'h2, 4'd0, 32'h40000000, 1'b1, 1'b0, 8'd4},         // R4 rise
    '{1'b0, 4'd0, 32'h0, 32'h0, 4'd0, 32'h40000000, 1'b1, 1'b0, 8'd4},         // R4 sticky
    '{1'b1, 4'd0, 32'h40000000, 32'h0, 4'd0, 32'h0, 1'b0, 1'b0, 8'd4},         // R4 clear
    '{1'b0, 4'd0, 32'h0, 32'h2, 4'd0, 32'h40000000, 1'b1, 1'b0, 8'd4},         // R4 rise again
    '{1'b1, 4'd0, 32'h40000000, 32'h2, 4'd0, 32'h0, 1'b0, 1'b0, 8'd4},         // R4 held high, no re-set
    '{1'b1, 4'd3, 32'h0000FFFF, 32'h0, 4'd3, 32'h0000FFFF, 1'b0, 1'b0, 8'd1},  // R1 critical select
    '{1'b1, 4'd1, 32'h00000101, 32'h0, 4'd1, 32'h00000101, 1'b0, 1'b1, 8'd5},  // R5 set, R7 crit out
    '{1'b1, 4'd8, 32'h12345007, 32'h0, 4'd8, 32'h12345005, 1'b0, 1'b1, 8'd9},  // R9 bit 1 dropped
    '{1'b0, 4'd0, 32'h0, 32'h0, 4'd7, 32'h12347E04, 1'b0, 1'b1, 8'd9},         // R9 downward scan
    '{1'b1, 4'd8, 32'h00010000, 32'h0, 4'd7, 32'h00010000, 1'b0, 1'b1, 8'd9},  // R9 upward scan
    '{1'b1, 4'd0, 32'h00000001, 32'h0, 4'd7, 32'h00011000, 1'b0, 1'b1, 8'd9},  // R9 next bit
    '{1'b1, 4'd2, 32'h000000FF, 32'h0, 4'd7, 32'h0, 1'b0, 1'b0, 8'd10},        // R10 none pending
    '{1'b1, 4'd2, 32'h80000100, 32'h0, 4'd6, 32'h00000100, 1'b0, 1'b1, 8'd8},  // R8 masked
    '{1'b1, 4'd1, 32'h80000000, 32'h0, 4'd6, 32'h80000100, 1'b1, 1'b1, 8'd6},  // R6 normal out
    '{1'b1, 4'd6, 32'hFFFFFFFF, 32'h0, 4'd2, 32'h80000100, 1'b1, 1'b1, 8'd12}, // R12 write 6
    '{1'b1, 4'd7, 32'hFFFFFFFF, 32'h0, 4'd7, 32'h00011000, 1'b1, 1'b1, 8'd12}, // R12 write 7
    '{1'b1, 4'd9, 32'hFFFFFFFF, 32'h0, 4'd9, 32'h0, 1'b1, 1'b1, 8'd12},        // R12 write 9
    '{1'b1, 4'd4, 32'hA5A5A5A5, 32'h0, 4'd4, 32'hA5A5A5A5, 1'b1, 1'b1, 8'd1},  // R1 polarity
    '{1'b0, 4'd0, 32'h0, 32'h0, 4'd1, 32'h80000100, 1'b1, 1'b1, 8'd1}          // R1 offset 1 mirror
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] wa, input logic [31:0] wd,
                      input logic [31:0] irq, input logic [3:0] ra);
    @(negedge clk);
    reg_wr = w; reg_addr = wa; reg_wdata = wd; irq_req = irq;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = ra;
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    for (int a = 0; a < 10; a++) begin
      reg_addr = 4'(a);
      #1;
      chk($sformatf("R13 read offset %0d", a), rdata, 32'h0);
    end
    chk("R13 normal out", {31'h0, irq_norm}, 32'h0);
    chk("R13 critical out", {31'h0, irq_crit}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(TBL[k].wr, TBL[k].waddr, TBL[k].wdata, TBL[k].irq, TBL[k].raddr);
      chk($sformatf("R%0d row %0d rdata", TBL[k].req, k), rdata, TBL[k].exp);
      chk($sformatf("R%0d row %0d normal", TBL[k].req, k), {31'h0, irq_norm}, {31'h0, TBL[k].n});
      chk($sformatf("R%0d row %0d critical", TBL[k].req, k), {31'h0, irq_crit}, {31'h0, TBL[k].c});
    end

    // R2 input 31 lands on status bit 0
    step(1'b0, 4'd0, 32'h0, 32'h80000000, 4'd0);
    chk("R2 input 31 to bit 0", rdata, 32'h80000101);

    // R11 vector offsets read zero when vector support is removed
    reg_addr = 4'd8;
    #1;
    chk("R11 main vector config", rdata, 32'h00010000);
    chk("R11 no-vector config", rdata_nv, 32'h0);
    reg_addr = 4'd7;
    #1;
    chk("R11 no-vector vector", rdata_nv, 32'h0);
    chk("R11 no-vector status path", {31'h0, irq_crit_nv}, 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule